// File: doc/BRIEF.md
# Delay-Line PHY Configuration Sequencer

This block steps a flash-interface PHY through its delay-line bring-up. The PHY has one master delay-locked loop and two slave delay lines, one for transmit and one for receive. A rising edge on the resync request starts a sequence. The block captures the mode, the 7-bit initial master delay and the 7-bit transmit and receive settings at that edge. In master mode it holds the loop in reset for one cycle while presenting the initial delay. It then releases reset together with a one-cycle master resync pulse and waits for the loop to report lock.

Once lock is reported, or at once in bypass mode, the block converts the settings into absolute tap counts and drives them to the slave lines. It also issues a one-cycle slave resync pulse. A fixed settle window must then pass before it raises `ready`, which tells the controller that a new transfer may begin.

In master mode each setting is taken as a fraction of the measured master tap count. The result is the product shifted right by 7, with a floor of one tap. In bypass mode each setting is passed through unchanged as a raw tap count. The transmit lane can instead use a quarter of the master count, which gives a quarter-period offset.

If lock does not arrive within a programmable limit, a sticky error is raised and the sequencer returns to idle without asserting `ready`.

Top module: `dly_phy_seq`

## Requirements
- R1: After reset, `ready`=0, `lock_err`=0, `tx_taps`=`rx_taps`=0, `dll_rst_n`=1, `dll_resync`=0 and `slv_resync`=0.
- R2: A sequence starts only on a 0-to-1 transition of `resync_req`. Holding `resync_req` at 1 starts nothing further, and `ready` stays at 1 while it is held.
- R3: In master mode (`cfg_bypass`=0), the first cycle after the starting edge has `dll_rst_n`=0 and `dll_init_dly` equal to the captured `cfg_init_dly`. The next cycle has `dll_rst_n`=1 and a single-cycle `dll_resync`=1.
- R4: In master mode, each lane tap count is floor(`ref_taps` × setting / 128). A result of 0 is replaced by 1.
- R5: In bypass mode (`cfg_bypass`=1), each lane tap count equals the raw setting, including 0. No loop reset is issued and no lock is waited for.
- R6: With `cfg_tx_dflt`=1, the transmit tap count is `ref_taps` >> 2, with a floor of 1, in either mode. The captured `cfg_tx_dly` is ignored.
- R7: `slv_resync` is a one-cycle pulse. `ready` rises exactly SETTLE_CYC+1 (21 by default) cycles after the cycle in which `slv_resync` is 1.
- R8: In master mode, if `dll_lock` stays low for `cfg_lock_limit`+1 cycles of waiting, `lock_err` becomes 1. The sequencer then returns to idle and `ready` stays 0.
- R9: A new starting edge clears `ready` on the next cycle. While `ready` is 1, `tx_taps` and `rx_taps` do not change.
- R10: `lock_err` stays at 1 until reset, even after a later sequence completes successfully.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bypass | input | 1 | 0 selects master mode, 1 selects bypass mode |
| cfg_tx_dflt | input | 1 | Use the quarter-period default for the transmit lane |
| cfg_init_dly | input | 7 | Initial master loop delay |
| cfg_tx_dly | input | 7 | Transmit delay setting |
| cfg_rx_dly | input | 7 | Receive delay setting |
| ref_taps | input | 7 | Master tap count per reference period |
| cfg_lock_limit | input | 16 | Lock wait limit in cycles |
| resync_req | input | 1 | Resync control; its rising edge starts a sequence |
| dll_lock | input | 1 | Loopback lock indication from the master loop |
| dll_rst_n | output | 1 | Active-low reset to the master loop |
| dll_init_dly | output | 7 | Initial delay presented to the master loop |
| dll_resync | output | 1 | Master resync pulse |
| slv_resync | output | 1 | Slave resync pulse |
| tx_taps | output | 7 | Absolute transmit tap count |
| rx_taps | output | 7 | Absolute receive tap count |
| ready | output | 1 | A new transfer may start |
| lock_err | output | 1 | Sticky lock-timeout error |

## Verification
The hardest condition to reach is a lock timeout followed by a recovery. The loop model normally asserts lock a few cycles after reset release, so the bench gates the model off and programs a short limit before issuing an edge. It then re-enables the model and runs a normal sequence to confirm that the error stays set while `ready` returns. The zero-result floor needs small products: a master count of 10 with settings of 5 and 0. Held-high resync is exercised by leaving the request at 1 for many cycles after `ready` rises.

// File: rtl/dly_phy_pkg.sv
package dly_phy_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_RELEASE,
        ST_WAIT,
        ST_APPLY,
        ST_SETTLE,
        ST_READY
    } seq_st_e;

    localparam int DEF_TAP_W  = 7;
    localparam int DEF_CNT_W  = 16;
    localparam int DEF_SETTLE = 20;

endpackage

// File: rtl/dly_edge_det.sv
module dly_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/dly_tap_conv.sv
module dly_tap_conv #(
    parameter int TAP_W = 7
) (
    input  logic             frac_en,
    input  logic             dflt_en,
    input  logic [TAP_W-1:0] master,
    input  logic [TAP_W-1:0] setting,
    output logic [TAP_W-1:0] taps
);
    localparam int PW = 2 * TAP_W;

    logic [PW-1:0]    prod;
    logic [TAP_W-1:0] scaled;
    logic [TAP_W-1:0] quarter;
    logic [TAP_W-1:0] pick;

    always_comb begin
        prod    = PW'(master) * PW'(setting);
        scaled  = TAP_W'(prod >> TAP_W);
        quarter = master >> 2;
        if (dflt_en)      pick = quarter;
        else if (frac_en) pick = scaled;
        else              pick = setting;
        if ((dflt_en || frac_en) && pick == '0) taps = TAP_W'(1);
        else                                   taps = pick;
    end
endmodule

// File: rtl/dly_phy_seq.sv
module dly_phy_seq
    import dly_phy_pkg::*;
#(
    parameter int TAP_W      = DEF_TAP_W,
    parameter int CNT_W      = DEF_CNT_W,
    parameter int SETTLE_CYC = DEF_SETTLE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_bypass,
    input  logic             cfg_tx_dflt,
    input  logic [TAP_W-1:0] cfg_init_dly,
    input  logic [TAP_W-1:0] cfg_tx_dly,
    input  logic [TAP_W-1:0] cfg_rx_dly,
    input  logic [TAP_W-1:0] ref_taps,
    input  logic [CNT_W-1:0] cfg_lock_limit,
    input  logic             resync_req,
    input  logic             dll_lock,
    output logic             dll_rst_n,
    output logic [TAP_W-1:0] dll_init_dly,
    output logic             dll_resync,
    output logic             slv_resync,
    output logic [TAP_W-1:0] tx_taps,
    output logic [TAP_W-1:0] rx_taps,
    output logic             ready,
    output logic             lock_err
);
    localparam int LANES = 2;
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic             byp;
        logic             tx_dflt;
        logic [TAP_W-1:0] init;
        logic [TAP_W-1:0] tx_set;
        logic [TAP_W-1:0] rx_set;
        logic [TAP_W-1:0] tx_taps;
        logic [TAP_W-1:0] rx_taps;
        logic             err;
    } seq_t;

    seq_t s_d, s_q;
    logic rise;

    logic [TAP_W-1:0] lane_set  [LANES];
    logic             lane_dflt [LANES];
    logic [TAP_W-1:0] lane_taps [LANES];

    dly_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (resync_req),
        .rise  (rise)
    );

    always_comb begin
        lane_set[0]  = s_q.tx_set;
        lane_set[1]  = s_q.rx_set;
        lane_dflt[0] = s_q.tx_dflt;
        lane_dflt[1] = 1'b0;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dly_tap_conv #(.TAP_W(TAP_W)) u_conv (
            .frac_en (~s_q.byp),
            .dflt_en (lane_dflt[g]),
            .master  (ref_taps),
            .setting (lane_set[g]),
            .taps    (lane_taps[g])
        );
    end

    always_comb begin
        s_d = s_q;
        if (rise) begin
            s_d.st      = cfg_bypass ? ST_APPLY : ST_HOLD;
            s_d.cnt     = '0;
            s_d.byp     = cfg_bypass;
            s_d.tx_dflt = cfg_tx_dflt;
            s_d.init    = cfg_init_dly;
            s_d.tx_set  = cfg_tx_dly;
            s_d.rx_set  = cfg_rx_dly;
        end else begin
            unique case (s_q.st)
                ST_HOLD: s_d.st = ST_RELEASE;
                ST_RELEASE: begin
                    s_d.st  = ST_WAIT;
                    s_d.cnt = '0;
                end
                ST_WAIT: begin
                    if (dll_lock) begin
                        s_d.st = ST_APPLY;
                    end else if (s_q.cnt == cfg_lock_limit) begin
                        s_d.st  = ST_IDLE;
                        s_d.err = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                ST_APPLY: begin
                    s_d.tx_taps = lane_taps[0];
                    s_d.rx_taps = lane_taps[1];
                    s_d.st      = ST_SETTLE;
                    s_d.cnt     = '0;
                end
                ST_SETTLE: begin
                    if (s_q.cnt == SETTLE_LAST) s_d.st  = ST_READY;
                    else                        s_d.cnt = s_q.cnt + 1'b1;
                end
                default: s_d.st = s_q.st;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign dll_rst_n    = (s_q.st != ST_HOLD);
    assign dll_init_dly = s_q.init;
    assign dll_resync   = (s_q.st == ST_RELEASE);
    assign slv_resync   = (s_q.st == ST_APPLY);
    assign ready        = (s_q.st == ST_READY);
    assign tx_taps      = s_q.tx_taps;
    assign rx_taps      = s_q.rx_taps;
    assign lock_err     = s_q.err;

    AST_HOLD_THEN_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !dll_rst_n |=> (dll_resync && dll_rst_n)); // R3
    AST_MST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dll_resync |=> !dll_resync); // R3
    AST_FRAC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !s_q.byp) |-> (tx_taps != '0 && rx_taps != '0)); // R4
    AST_SLV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        slv_resync |=> !slv_resync); // R7
    AST_READY_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(s_q.st) == ST_SETTLE)); // R7
    AST_ERR_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_err) |-> !ready); // R8
    AST_TAPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready)) |-> ($stable(tx_taps) && $stable(rx_taps))); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err |=> lock_err); // R10
endmodule

// File: tb/dly_phy_seq_tb.sv
module dly_lock_model #(
    parameter int LOCK_DLY = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic loop_rst_n,
    output logic lock
);
    int cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || !loop_rst_n) begin
            cnt  <= 0;
            lock <= 1'b0;
        end else if (!en) begin
            lock <= 1'b0;
        end else if (cnt >= LOCK_DLY) begin
            lock <= 1'b1;
        end else begin
            cnt <= cnt + 1;
        end
    end
endmodule

module dly_phy_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_bypass = 1'b0;
    logic       cfg_tx_dflt = 1'b0;
    logic [6:0] cfg_init_dly = '0;
    logic [6:0] cfg_tx_dly = '0;
    logic [6:0] cfg_rx_dly = '0;
    logic [6:0] ref_taps = '0;
    logic [15:0] cfg_lock_limit = 16'd200;
    logic       resync_req = 1'b0;
    logic       lock_en = 1'b1;
    logic       dll_lock;
    logic       dll_rst_n, dll_resync, slv_resync, ready, lock_err;
    logic [6:0] dll_init_dly, tx_taps, rx_taps;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dly_phy_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .cfg_tx_dflt(cfg_tx_dflt),
        .cfg_init_dly(cfg_init_dly), .cfg_tx_dly(cfg_tx_dly), .cfg_rx_dly(cfg_rx_dly),
        .ref_taps(ref_taps), .cfg_lock_limit(cfg_lock_limit), .resync_req(resync_req),
        .dll_lock(dll_lock), .dll_rst_n(dll_rst_n), .dll_init_dly(dll_init_dly),
        .dll_resync(dll_resync), .slv_resync(slv_resync), .tx_taps(tx_taps),
        .rx_taps(rx_taps), .ready(ready), .lock_err(lock_err)
    );

    dly_lock_model u_lock (
        .clk(clk), .rst_n(rst_n), .en(lock_en), .loop_rst_n(dll_rst_n), .lock(dll_lock)
    );

    typedef struct packed {
        logic       byp;
        logic       dflt;
        logic [6:0] mref;
        logic [6:0] tx;
        logic [6:0] rx;
        logic [6:0] etx;
        logic [6:0] erx;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 7'd100, 7'd64,  7'd32,  7'd50,  7'd25},
        '{1'b0, 1'b0, 7'd127, 7'd127, 7'd1,   7'd126, 7'd1},
        '{1'b0, 1'b0, 7'd10,  7'd5,   7'd0,   7'd1,   7'd1},
        '{1'b1, 1'b0, 7'd80,  7'd17,  7'd0,   7'd17,  7'd0},
        '{1'b0, 1'b1, 7'd80,  7'd3,   7'd96,  7'd20,  7'd60},
        '{1'b1, 1'b1, 7'd2,   7'd9,   7'd127, 7'd1,   7'd127},
        '{1'b0, 1'b0, 7'd64,  7'd100, 7'd50,  7'd50,  7'd25}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drop_req();
        @(negedge clk);
        resync_req = 1'b0;
        @(negedge clk);
    endtask

    // Run one sequence; returns settle count and whether loop reset was seen
    task automatic run_seq(output int n, output bit saw_rst);
        int c;
        drop_req();
        resync_req = 1'b1;
        n = -1;
        saw_rst = 1'b0;
        c = 0;
        do begin
            @(negedge clk);
            c++;
            if (!dll_rst_n) saw_rst = 1'b1;
            if (n >= 0) n++;
            if (slv_resync) n = 0;
        end while (!ready && c < 500);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        bit saw;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ready == 1'b0, "R1 ready", ready, 0);
        chk(lock_err == 1'b0, "R1 lock_err", lock_err, 0);
        chk(tx_taps == 7'd0 && rx_taps == 7'd0, "R1 taps", tx_taps, 0);
        chk(dll_rst_n == 1'b1, "R1 dll_rst_n", dll_rst_n, 1);
        chk(dll_resync == 1'b0 && slv_resync == 1'b0, "R1 pulses", dll_resync, 0);

        // Table: R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            cfg_bypass  = VEC[i].byp;
            cfg_tx_dflt = VEC[i].dflt;
            ref_taps    = VEC[i].mref;
            cfg_tx_dly  = VEC[i].tx;
            cfg_rx_dly  = VEC[i].rx;
            run_seq(n, saw);
            chk(ready == 1'b1, "R7 ready reached", ready, 1);
            chk(n == 21, "R7 settle count", n, 21);
            chk(tx_taps == VEC[i].etx, VEC[i].dflt ? "R6 tx default" :
                (VEC[i].byp ? "R5 tx raw" : "R4 tx frac"), tx_taps, VEC[i].etx);
            chk(rx_taps == VEC[i].erx, VEC[i].byp ? "R5 rx raw" : "R4 rx frac",
                rx_taps, VEC[i].erx);
            chk(saw == !VEC[i].byp, VEC[i].byp ? "R5 no loop reset" : "R3 loop reset",
                saw, !VEC[i].byp);
        end

        // R2: holding the request high starts nothing
        saw = 1'b0;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (!dll_rst_n || slv_resync || !ready) saw = 1'b1;
        end
        chk(saw == 1'b0, "R2 held high no restart", saw, 0);
        chk(ready == 1'b1, "R2 ready kept", ready, 1);
        chk(tx_taps == 7'd50 && rx_taps == 7'd25, "R9 taps stable", tx_taps, 50);

        // R3 detail and R9 ready drop on a new edge
        cfg_bypass   = 1'b0;
        cfg_tx_dflt  = 1'b0;
        cfg_init_dly = 7'd33;
        drop_req();
        resync_req = 1'b1;
        @(negedge clk);
        chk(ready == 1'b0, "R9 ready cleared", ready, 0);
        chk(dll_rst_n == 1'b0, "R3 reset low", dll_rst_n, 0);
        chk(dll_init_dly == 7'd33, "R3 init delay", dll_init_dly, 33);
        @(negedge clk);
        chk(dll_rst_n == 1'b1 && dll_resync == 1'b1, "R3 release+resync", dll_resync, 1);
        @(negedge clk);
        chk(dll_resync == 1'b0, "R3 resync single", dll_resync, 0);
        for (int c = 0; c < 60 && !ready; c++) @(negedge clk);
        chk(ready == 1'b1, "R3 ready after lock", ready, 1);

        // R8 lock timeout
        lock_en = 1'b0;
        cfg_lock_limit = 16'd10;
        drop_req();
        resync_req = 1'b1;
        saw = 1'b0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (ready) saw = 1'b1;
        end
        chk(lock_err == 1'b1, "R8 lock_err set", lock_err, 1);
        chk(saw == 1'b0 && ready == 1'b0, "R8 no ready", saw, 0);

        // R10 sticky error across a later good sequence
        lock_en = 1'b1;
        cfg_lock_limit = 16'd200;
        run_seq(n, saw);
        chk(ready == 1'b1, "R10 recovery ready", ready, 1);
        chk(lock_err == 1'b1, "R10 lock_err sticky", lock_err, 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule